// File: doc/BRIEF.md
# Duplicated-Copy Partition Parity Corrector

This block is the read-path and write-path logic for a cache line that is stored twice. The line is split into equal-width partitions. Each partition of each copy carries one even-parity bit. On a write, the block produces two identical copies of the line, together with their parity bits. On a read, it takes both stored copies and their parity bits and checks each partition on its own. When exactly one copy passes parity, that copy is selected. When the copies agree and both pass, the data goes through unchanged. In every other case the partition is flagged as uncorrectable.

For each partition the block reports three things: a corrected flag, an uncorrectable flag, and the bit positions where the two copies disagree. Tag lookup, arrays and any recovery action sit outside the block and use these flags. The block is purely combinational.

Top module: `dup_parity_corrector`

## Requirements
- R1: On the write side, `wr_copy_a` and `wr_copy_b` both equal `wr_data`. `wr_par_a[i]` and `wr_par_b[i]` both equal the XOR of `wr_data[i*PART_W +: PART_W]`. This is even parity: the partition bits plus the parity bit hold an even number of ones.
- R2: A read partition passes through cleanly when both copies are equal and both pass even parity. In that case the output equals the copy and neither flag is set.
- R3: Exactly one copy of a read partition may fail parity. This covers an odd number of flips in that copy's data or in its parity bit. The output partition is then the other copy, `rd_fix[i]`=1 and `rd_bad[i]`=0.
- R4: The two copies of a partition may differ while both pass parity, as with an even number of flips in one copy. Then `rd_bad[i]`=1, `rd_fix[i]`=0, and the output partition is copy A.
- R5: Both copies of a partition may fail parity. Then `rd_bad[i]`=1, `rd_fix[i]`=0, and the output partition is copy A.
- R6: `rd_diff` is the bitwise XOR of the two read copies across the whole line, whatever the parity outcome.
- R7: Partitions are independent. The flags and data of one partition depend only on that partition's bits and parity bits. `LINE_W` must equal `N_PART*PART_W`.
- R8: `rd_fix[i]` and `rd_bad[i]` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_data | input | LINE_W | Line to be written |
| wr_copy_a | output | LINE_W | Data for copy A |
| wr_copy_b | output | LINE_W | Data for copy B |
| wr_par_a | output | N_PART | Parity bits for copy A |
| wr_par_b | output | N_PART | Parity bits for copy B |
| rd_copy_a | input | LINE_W | Stored copy A |
| rd_copy_b | input | LINE_W | Stored copy B |
| rd_par_a | input | N_PART | Stored parity bits of copy A |
| rd_par_b | input | N_PART | Stored parity bits of copy B |
| rd_data | output | LINE_W | Corrected line |
| rd_fix | output | N_PART | Partition was corrected |
| rd_bad | output | N_PART | Partition has an uncorrectable fault |
| rd_diff | output | LINE_W | Bit positions where the copies differ |

## Verification
The checker holds several properties on every input pattern:
- the two write copies are identical and each carries even parity;
- the two flags are exclusive;
- an unflagged or corrected partition always equals one of the stored copies;
- a clean, agreeing partition raises no flag.

Only the bench scenarios can show the finer points:
- which copy is selected when one copy fails;
- the difference between an even flip count in one copy and faults spread across both copies;
- a fault caused only by a flipped parity bit;
- the independence of neighbouring partitions, including the last one.

// File: rtl/dup_parity_corrector.sv
module dup_parity_corrector #(
  parameter int LINE_W = 64,
  parameter int PART_W = 8,
  parameter int N_PART = LINE_W / PART_W
) (
  input  logic [LINE_W-1:0] wr_data,
  output logic [LINE_W-1:0] wr_copy_a,
  output logic [LINE_W-1:0] wr_copy_b,
  output logic [N_PART-1:0] wr_par_a,
  output logic [N_PART-1:0] wr_par_b,
  input  logic [LINE_W-1:0] rd_copy_a,
  input  logic [LINE_W-1:0] rd_copy_b,
  input  logic [N_PART-1:0] rd_par_a,
  input  logic [N_PART-1:0] rd_par_b,
  output logic [LINE_W-1:0] rd_data,
  output logic [N_PART-1:0] rd_fix,
  output logic [N_PART-1:0] rd_bad,
  output logic [LINE_W-1:0] rd_diff
);

  assign wr_copy_a = wr_data;
  assign wr_copy_b = wr_data;
  assign rd_diff   = rd_copy_a ^ rd_copy_b;

  for (genvar g = 0; g < N_PART; g++) begin : g_part
    localparam int LO = g * PART_W;
    logic [PART_W-1:0] pa, pb;
    logic ok_a, ok_b, agree;

    assign pa    = rd_copy_a[LO +: PART_W];
    assign pb    = rd_copy_b[LO +: PART_W];
    assign ok_a  = ~^{pa, rd_par_a[g]};
    assign ok_b  = ~^{pb, rd_par_b[g]};
    assign agree = (pa == pb);

    assign wr_par_a[g] = ^wr_data[LO +: PART_W];
    assign wr_par_b[g] = ^wr_data[LO +: PART_W];

    assign rd_fix[g] = ok_a ^ ok_b;
    assign rd_bad[g] = ~(ok_a ^ ok_b) & ~(ok_a & ok_b & agree);
    assign rd_data[LO +: PART_W] = (ok_b & ~ok_a) ? pb : pa;
  end

endmodule

// File: rtl/dup_parity_corrector_chk.sv
module dup_parity_corrector_chk #(
  parameter int LINE_W = 64,
  parameter int PART_W = 8,
  parameter int N_PART = LINE_W / PART_W
) (
  input logic [LINE_W-1:0] wr_data,
  input logic [LINE_W-1:0] wr_copy_a,
  input logic [LINE_W-1:0] wr_copy_b,
  input logic [N_PART-1:0] wr_par_a,
  input logic [N_PART-1:0] wr_par_b,
  input logic [LINE_W-1:0] rd_copy_a,
  input logic [LINE_W-1:0] rd_copy_b,
  input logic [N_PART-1:0] rd_par_a,
  input logic [N_PART-1:0] rd_par_b,
  input logic [LINE_W-1:0] rd_data,
  input logic [N_PART-1:0] rd_fix,
  input logic [N_PART-1:0] rd_bad,
  input logic [LINE_W-1:0] rd_diff
);

  // R7: geometry must tile the line exactly
  initial a_r7_geometry: assert (LINE_W == N_PART * PART_W);

  always_comb begin
    a_r1_same_copies: assert (wr_copy_a == wr_copy_b && wr_par_a == wr_par_b && wr_copy_a == wr_data);
    a_r8_exclusive: assert ((rd_fix & rd_bad) == '0);
    for (int i = 0; i < N_PART; i++) begin
      a_r1_even_parity: assert (^{wr_copy_a[i*PART_W +: PART_W], wr_par_a[i]} == 1'b0);
      // R3: a non-bad partition always carries one of the stored copies
      a_r3_from_copy: assert (rd_bad[i] ||
        rd_data[i*PART_W +: PART_W] == rd_copy_a[i*PART_W +: PART_W] ||
        rd_data[i*PART_W +: PART_W] == rd_copy_b[i*PART_W +: PART_W]);
      // R2/R6: no difference and both parities good means a clean partition
      a_r2_clean: assert (!(rd_diff[i*PART_W +: PART_W] == '0 && rd_par_a[i] == rd_par_b[i] &&
        ^{rd_copy_a[i*PART_W +: PART_W], rd_par_a[i]} == 1'b0) ||
        (!rd_fix[i] && !rd_bad[i] && rd_data[i*PART_W +: PART_W] == rd_copy_a[i*PART_W +: PART_W]));
    end
  end

endmodule

bind dup_parity_corrector dup_parity_corrector_chk #(
  .LINE_W(LINE_W), .PART_W(PART_W), .N_PART(N_PART)
) u_chk (
  .wr_data(wr_data), .wr_copy_a(wr_copy_a), .wr_copy_b(wr_copy_b),
  .wr_par_a(wr_par_a), .wr_par_b(wr_par_b),
  .rd_copy_a(rd_copy_a), .rd_copy_b(rd_copy_b),
  .rd_par_a(rd_par_a), .rd_par_b(rd_par_b),
  .rd_data(rd_data), .rd_fix(rd_fix), .rd_bad(rd_bad), .rd_diff(rd_diff)
);

// File: tb/tb_dup_parity_corrector.sv
module tb_dup_parity_corrector;
  localparam int LW = 64;
  localparam int PW = 8;
  localparam int NP = LW / PW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [LW-1:0] wr_data = '0, rd_copy_a = '0, rd_copy_b = '0;
  logic [NP-1:0] rd_par_a = '0, rd_par_b = '0;
  logic [LW-1:0] wr_copy_a, wr_copy_b, rd_data, rd_diff;
  logic [NP-1:0] wr_par_a, wr_par_b, rd_fix, rd_bad;

  dup_parity_corrector #(.LINE_W(LW), .PART_W(PW)) dut (
    .wr_data(wr_data), .wr_copy_a(wr_copy_a), .wr_copy_b(wr_copy_b),
    .wr_par_a(wr_par_a), .wr_par_b(wr_par_b),
    .rd_copy_a(rd_copy_a), .rd_copy_b(rd_copy_b),
    .rd_par_a(rd_par_a), .rd_par_b(rd_par_b),
    .rd_data(rd_data), .rd_fix(rd_fix), .rd_bad(rd_bad), .rd_diff(rd_diff));

  typedef struct {
    logic [LW-1:0] wa, wb, data, diff;
    logic [NP-1:0] wpa, wpb, fix, bad;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  function automatic logic [NP-1:0] parity_of(input logic [LW-1:0] x);
    logic [NP-1:0] p;
    for (int i = 0; i < NP; i++) p[i] = ^x[i*PW +: PW];
    return p;
  endfunction

  task automatic drive(input logic [LW-1:0] w, a, b, input logic [NP-1:0] pa, pb, input string tag);
    exp_t e;
    e.wa = w; e.wb = w; e.wpa = parity_of(w); e.wpb = parity_of(w);
    e.diff = a ^ b; e.fix = '0; e.bad = '0; e.tag = tag;
    for (int i = 0; i < NP; i++) begin
      logic [PW-1:0] xa, xb;
      logic oa, ob;
      xa = a[i*PW +: PW]; xb = b[i*PW +: PW];
      oa = ((^xa) == pa[i]); ob = ((^xb) == pb[i]);
      e.data[i*PW +: PW] = xa;
      if (oa != ob) begin
        e.fix[i] = 1'b1;
        if (ob) e.data[i*PW +: PW] = xb;
      end else if (!(oa && ob && xa == xb)) e.bad[i] = 1'b1;
    end
    @(posedge clk);
    wr_data <= w; rd_copy_a <= a; rd_copy_b <= b; rd_par_a <= pa; rd_par_b <= pb;
    q.push_back(e);
  endtask

  task automatic cmp(input string tag, input string what, input logic [LW-1:0] act, exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (q.size() > 0) begin
    exp_t e;
    e = q.pop_front();
    cmp(e.tag, "wr_copy_a", wr_copy_a, e.wa);
    cmp(e.tag, "wr_copy_b", wr_copy_b, e.wb);
    cmp(e.tag, "wr_par_a", LW'(wr_par_a), LW'(e.wpa));
    cmp(e.tag, "wr_par_b", LW'(wr_par_b), LW'(e.wpb));
    cmp(e.tag, "rd_data", rd_data, e.data);
    cmp(e.tag, "rd_diff", rd_diff, e.diff);
    cmp(e.tag, "rd_fix", LW'(rd_fix), LW'(e.fix));
    cmp(e.tag, "rd_bad", LW'(rd_bad), LW'(e.bad));
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [LW-1:0] w, a, b;
    logic [NP-1:0] p;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    drive('0, '0, '0, '0, '0, "R2 reset-state zero line");
    w = 64'h0123_4567_89ab_cdef; p = parity_of(w);
    drive(w, w, w, p, p, "R1 R2 clean");
    w = 64'hffff_0000_a5a5_5a5a; p = parity_of(w);
    drive(w, w, w, p, p, "R1 R2 clean pattern");
    // R3: one flip in copy B, partition 2 -> take A
    drive(w, w, w ^ 64'h0000_0000_0004_0000, p, p, "R3 single flip B");
    // R3: three flips in copy A, partition 0 -> take B
    drive(w, w ^ 64'h0000_0000_0000_0007, w, p, p, "R3 triple flip A");
    // R3: only copy B parity bit flipped, partition 4
    drive(w, w, w, p, p ^ 8'h10, "R3 parity bit B");
    // R3: last partition, copy A single flip
    drive(w, w ^ 64'h8000_0000_0000_0000, w, p, p, "R3 last partition");
    // R4: two flips in copy A, partition 5
    drive(w, w ^ 64'h0000_0300_0000_0000, w, p, p, "R4 even flips");
    // R5: one flip in each copy, partition 1
    drive(w, w ^ 64'h0000_0000_0000_0100, w ^ 64'h0000_0000_0000_0400, p, p, "R5 both copies");
    // R5: same bit flipped in both copies
    drive(w, w ^ 64'h0000_0000_0000_0010, w ^ 64'h0000_0000_0000_0010, p, p, "R5 same bit");
    // R6 R7 R8: mixed faults in separate partitions
    drive(w, w ^ 64'h0300_0000_0000_0001, w ^ 64'h0000_0010_0000_0001, p, p, "R6 R7 R8 mixed");
    for (int k = 0; k < 400; k++) begin
      w = {$urandom, $urandom}; p = parity_of(w);
      a = w; b = w;
      for (int j = 0; j < 3; j++) begin
        if ($urandom_range(1, 0) == 1) a[$urandom_range(LW-1, 0)] ^= 1'b1;
        if ($urandom_range(2, 0) == 0) b[$urandom_range(LW-1, 0)] ^= 1'b1;
      end
      drive(w, a, b, p ^ NP'($urandom_range(3, 0) == 0 ? (1 << $urandom_range(NP-1, 0)) : 0), p, "R7 random");
    end
    repeat (3) @(posedge clk);
    summary();
  end
endmodule